// File: doc/BRIEF.md
# Four-Module Clone Redundancy Voter

This block accepts the results of four identical, independently computed copies of a control function, such as the duty command of a digital compensator. It produces one masked result. Every module value is judged against the other modules that are still trusted. A module that disagrees with a majority group is marked faulty and stays marked, so later votes ignore it. The output follows the largest group of trusted modules that agree.

The modules are also laid out as six duplex slots in three pairs. Four slots hold the physical modules and two hold clones of surviving modules. Each pair has a disagreement detector, and a repair process can use these pair error flags. When a module is dropped, the slots are filled again from the survivors, so any good module can act as a spare for any pair. If the trusted modules leave no agreeing group of two, a fatal flag is raised and the last good output is held.

Top module: `quad_clone_voter`

## Requirements
- R1: While reset is asserted, and after it is released with all module inputs equal, `voted_o` is 0, `mod_fault_o` is 0, `pair_err_o` is 0 and `fatal_o` is 0.
- R2: A vector on `mod_vals_i` and `flag_clr_i` present before clock edge k is registered at edge k. Its effect on every output appears after edge k+1. Module m occupies bits [DATA_W*m+DATA_W-1 : DATA_W*m].
- R3: The trusted modules are those whose `mod_fault_o` bit is 0. `voted_o` takes the value held by the largest group of trusted modules with equal values. The group must have at least two members. If two groups are the same size, the group containing the lowest module index wins.
- R4: When a winning group exists, a trusted module whose value differs from it gets its `mod_fault_o` bit m set. The bit stays set until a clear.
- R5: Modules that are already flagged have no influence on the vote. The output stays correct when any two of the four modules fail, whether the failures come one after another or in the same vector with distinct wrong values.
- R6: Slot s (0..5) is filled by the trusted module of rank (s mod k), where k is the number of trusted modules and rank orders modules by index. Pair p compares slot 2p with slot 2p+1. `pair_err_o[p]` is 1 when the two slot values differ.
- R7: When no group of two or more trusted modules agrees, `fatal_o` is 1, `voted_o` keeps its previous value and no new fault bit is set.
- R8: `flag_clr_i` is registered together with the data. The vector it accompanies is judged as if all four modules were trusted. The fault bits then become exactly the flags produced by that vector.
- R9: At least two modules remain unflagged at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mod_vals_i | input | 4*DATA_W | Results of the four module copies, module m in slice m |
| flag_clr_i | input | 1 | Clears the sticky fault bits together with the vector it accompanies |
| voted_o | output | DATA_W | Masked voted result |
| mod_fault_o | output | 4 | Sticky per-module fault bits |
| pair_err_o | output | 3 | Per-pair disagreement flags for a repair process |
| fatal_o | output | 1 | No agreeing group of trusted modules; output held |

## Verification
The bench builds the block with DATA_W = 8. At that width, a grounded input, a bit-inverted input and the good value are all distinct. This makes it possible to test two failures in the same vector with two different wrong values. With four modules, the six possible failure pairs are walked exhaustively. Each pair is tested both as a one-after-another failure and as a same-vector failure, and `voted_o` is checked for no change. Directed vectors cover the equal-size tie, the hold under a fatal condition, and the slot refill after the survivors drop to three and then to two. These vectors give fixed expected pair flag patterns.

// File: rtl/qcv_pkg.sv
package qcv_pkg;
  localparam int unsigned N_MOD     = 4;
  localparam int unsigned N_CLONE   = 2;
  localparam int unsigned N_SLOT    = N_MOD + N_CLONE;
  localparam int unsigned N_PAIR    = N_SLOT / 2;
  localparam int unsigned IDX_W     = $clog2(N_MOD);
  localparam int unsigned CNT_W     = $clog2(N_MOD + 1);
  localparam int unsigned MIN_GROUP = 2;

  typedef logic [N_MOD-1:0]  mod_mask_t;
  typedef logic [N_PAIR-1:0] pair_mask_t;
endpackage

// File: rtl/qcv_rst_sync.sv
module qcv_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/qcv_in_stage.sv
module qcv_in_stage
  import qcv_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_MOD*DATA_W-1:0] vals_i,
  input  logic                    clr_i,
  output logic [N_MOD*DATA_W-1:0] vals_q,
  output logic                    clr_q
);
  logic [N_MOD*DATA_W-1:0] vals_d;
  logic                    clr_d;

  always_comb begin
    vals_d = vals_i;
    clr_d  = clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vals_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      vals_q <= vals_d;
      clr_q  <= clr_d;
    end
  end
endmodule

// File: rtl/qcv_group_vote.sv
module qcv_group_vote
  import qcv_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_MOD*DATA_W-1:0] vals_i,
  input  mod_mask_t               healthy_i,
  output logic [DATA_W-1:0]       win_val_o,
  output logic                    valid_o,
  output mod_mask_t               bad_o
);
  logic [N_MOD-1:0][CNT_W-1:0] grp_cnt;
  logic [CNT_W-1:0]            best_cnt;
  logic [IDX_W-1:0]            win_idx;

  // size of the agreeing trusted group each trusted module belongs to
  always_comb begin
    for (int i = 0; i < N_MOD; i++) begin
      grp_cnt[i] = '0;
      if (healthy_i[i]) begin
        for (int j = 0; j < N_MOD; j++) begin
          if (healthy_i[j] &&
              (vals_i[i*DATA_W +: DATA_W] == vals_i[j*DATA_W +: DATA_W]))
            grp_cnt[i] = grp_cnt[i] + CNT_W'(1);
        end
      end
    end
  end

  // strictly-greater scan keeps the lowest index on a tie
  always_comb begin
    best_cnt = '0;
    win_idx  = '0;
    for (int i = 0; i < N_MOD; i++) begin
      if (grp_cnt[i] > best_cnt) begin
        best_cnt = grp_cnt[i];
        win_idx  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    valid_o   = (best_cnt >= CNT_W'(MIN_GROUP));
    win_val_o = vals_i[win_idx*DATA_W +: DATA_W];
    for (int i = 0; i < N_MOD; i++)
      bad_o[i] = valid_o && healthy_i[i] &&
                 (vals_i[i*DATA_W +: DATA_W] != win_val_o);
  end

  AST_WINNER_TRUSTED: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> healthy_i[win_idx]); // R3
endmodule

// File: rtl/qcv_pair_check.sv
module qcv_pair_check
  import qcv_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [N_MOD*DATA_W-1:0] vals_i,
  input  mod_mask_t               healthy_i,
  output pair_mask_t              pair_err_o
);
  logic [N_MOD-1:0][CNT_W-1:0]   rank;
  logic [CNT_W-1:0]              live;
  logic [N_SLOT-1:0][DATA_W-1:0] slot_val;
  logic [N_SLOT-1:0][CNT_W-1:0]  want;

  // rank of each trusted module among the trusted ones, by index
  always_comb begin
    live = '0;
    for (int m = 0; m < N_MOD; m++) begin
      rank[m] = live;
      if (healthy_i[m]) live = live + CNT_W'(1);
    end
  end

  // slot s takes the survivor of rank (s mod live); slots past N_MOD are clones
  always_comb begin
    for (int s = 0; s < N_SLOT; s++) begin
      if (live < CNT_W'(MIN_GROUP)) want[s] = '0;
      else                          want[s] = CNT_W'(s % int'(live));
      slot_val[s] = '0;
      for (int m = 0; m < N_MOD; m++) begin
        if (healthy_i[m] && (rank[m] == want[s]))
          slot_val[s] = vals_i[m*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < N_PAIR; p++)
      pair_err_o[p] = (live >= CNT_W'(MIN_GROUP)) &&
                      (slot_val[2*p] != slot_val[2*p+1]);
  end
endmodule

// File: rtl/quad_clone_voter.sv
module quad_clone_voter
  import qcv_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_MOD*DATA_W-1:0] mod_vals_i,
  input  logic                    flag_clr_i,
  output logic [DATA_W-1:0]       voted_o,
  output logic [N_MOD-1:0]        mod_fault_o,
  output logic [N_PAIR-1:0]       pair_err_o,
  output logic                    fatal_o
);
  logic                    srst_n;
  logic [N_MOD*DATA_W-1:0] vals_q;
  logic                    clr_q;
  mod_mask_t               trusted;
  logic [DATA_W-1:0]       win_val;
  logic                    vote_valid;
  mod_mask_t               bad;
  pair_mask_t              pair_err;

  logic [DATA_W-1:0] voted_q, voted_d;
  mod_mask_t         flt_q, flt_d;
  pair_mask_t        perr_q, perr_d;
  logic              fatal_q, fatal_d;
  logic              vote_en;

  qcv_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  qcv_in_stage #(.DATA_W(DATA_W)) u_in (
    .clk    (clk),
    .rst_n  (srst_n),
    .vals_i (mod_vals_i),
    .clr_i  (flag_clr_i),
    .vals_q (vals_q),
    .clr_q  (clr_q)
  );

  // a clear makes the accompanying vector see all modules as trusted
  assign trusted = clr_q ? '1 : ~flt_q;

  qcv_group_vote #(.DATA_W(DATA_W)) u_vote (
    .clk       (clk),
    .rst_n     (srst_n),
    .vals_i    (vals_q),
    .healthy_i (trusted),
    .win_val_o (win_val),
    .valid_o   (vote_valid),
    .bad_o     (bad)
  );

  qcv_pair_check #(.DATA_W(DATA_W)) u_pairs (
    .vals_i     (vals_q),
    .healthy_i  (trusted),
    .pair_err_o (pair_err)
  );

  always_comb begin
    vote_en = vote_valid;
    voted_d = win_val;
    flt_d   = (clr_q ? '0 : flt_q) | bad;
    perr_d  = pair_err;
    fatal_d = !vote_valid;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      voted_q <= '0;
      flt_q   <= '0;
      perr_q  <= '0;
      fatal_q <= 1'b0;
    end else begin
      if (vote_en) voted_q <= voted_d;
      flt_q   <= flt_d;
      perr_q  <= perr_d;
      fatal_q <= fatal_d;
    end
  end

  assign voted_o     = voted_q;
  assign mod_fault_o = flt_q;
  assign pair_err_o  = perr_q;
  assign fatal_o     = fatal_q;

  AST_FATAL_HOLDS_OUT: assert property (@(posedge clk) disable iff (!srst_n)
    fatal_o |-> $stable(voted_o)); // R7
  AST_FATAL_NO_NEW_FLAG: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr_q && !vote_valid) |=> $stable(mod_fault_o)); // R7
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!srst_n)
    !clr_q |=> ((mod_fault_o & $past(mod_fault_o)) == $past(mod_fault_o))); // R4
  AST_TWO_SURVIVE: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(~mod_fault_o) >= 2); // R9
endmodule

// File: tb/tb_quad_clone_voter.sv
`timescale 1ns/1ps
module tb_quad_clone_voter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mod_vals_i = '0;
  logic        flag_clr_i = 1'b0;
  logic [7:0]  voted_o;
  logic [3:0]  mod_fault_o;
  logic [2:0]  pair_err_o;
  logic        fatal_o;

  int n_vec = 0;
  int n_err = 0;
  int cyc   = 0;

  typedef struct {
    int         due;
    logic [7:0] eo;
    logic [3:0] ef;
    logic       ea;
    logic [2:0] ep;
    logic       cp;
    string      req;
  } item_t;
  item_t sbq[$];
  item_t it;
  logic  bad;
  logic [7:0] g, g2;
  int pidx;

  quad_clone_voter #(.DATA_W(8)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mod_vals_i  (mod_vals_i),
    .flag_clr_i  (flag_clr_i),
    .voted_o     (voted_o),
    .mod_fault_o (mod_fault_o),
    .pair_err_o  (pair_err_o),
    .fatal_o     (fatal_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // driver: apply one vector for one cycle, push what the requirements predict
  task automatic send(input logic [31:0] v, input logic clr, input logic [7:0] eo,
                      input logic [3:0] ef, input logic ea, input logic [2:0] ep,
                      input logic cp, input string req);
    item_t x;
    @(negedge clk);
    mod_vals_i = v;
    flag_clr_i = clr;
    x.due = cyc + 2; x.eo = eo; x.ef = ef; x.ea = ea; x.ep = ep; x.cp = cp; x.req = req;
    sbq.push_back(x);
  endtask

  function automatic logic [31:0] mk(input logic [7:0] good, input int a, input logic [7:0] va,
                                     input int b, input logic [7:0] vb);
    logic [31:0] r;
    for (int m = 0; m < 4; m++)
      r[8*m +: 8] = (m == a) ? va : ((m == b) ? vb : good);
    return r;
  endfunction

  // monitor: compare when each result is due (R2 timing)
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      it = sbq.pop_front();
      n_vec++;
      bad = 1'b0;
      if (voted_o !== it.eo) begin
        $display("FAIL %s voted_o act=%h exp=%h", it.req, voted_o, it.eo); bad = 1'b1;
      end
      if (mod_fault_o !== it.ef) begin
        $display("FAIL %s mod_fault_o act=%b exp=%b", it.req, mod_fault_o, it.ef); bad = 1'b1;
      end
      if (fatal_o !== it.ea) begin
        $display("FAIL %s fatal_o act=%b exp=%b", it.req, fatal_o, it.ea); bad = 1'b1;
      end
      if (it.cp && pair_err_o !== it.ep) begin
        $display("FAIL %s pair_err_o act=%b exp=%b", it.req, pair_err_o, it.ep); bad = 1'b1;
      end
      if (bad) n_err++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired act=running exp=done");
    n_err++;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    n_vec++; // R1 during reset
    if (voted_o !== 8'h00 || mod_fault_o !== 4'h0 || pair_err_o !== 3'b000 || fatal_o !== 1'b0) begin
      $display("FAIL R1 reset state act=%h/%b/%b/%b exp=00/0000/000/0",
               voted_o, mod_fault_o, pair_err_o, fatal_o);
      n_err++;
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_vec++; // R1 after release
    if (voted_o !== 8'h00 || mod_fault_o !== 4'h0 || pair_err_o !== 3'b000 || fatal_o !== 1'b0) begin
      $display("FAIL R1 post-reset act=%h/%b/%b/%b exp=00/0000/000/0",
               voted_o, mod_fault_o, pair_err_o, fatal_o);
      n_err++;
    end

    // directed: values packed {m3,m2,m1,m0}
    send(32'h3C3C3C3C, 1, 8'h3C, 4'b0000, 0, 3'b000, 1, "R2 R3 all agree");
    send(32'h113C3C3C, 0, 8'h3C, 4'b1000, 0, 3'b010, 1, "R4 R6 module3 flagged");
    send(32'h3C3C3C3C, 0, 8'h3C, 4'b1000, 0, 3'b000, 1, "R4 sticky R6 three survivors");
    send(32'h773C003C, 0, 8'h3C, 4'b1010, 0, 3'b101, 1, "R5 R6 module1 grounded");
    send(32'h00500050, 0, 8'h50, 4'b1010, 0, 3'b000, 1, "R5 two survivors");
    send(32'h00510050, 0, 8'h50, 4'b1010, 1, 3'b111, 1, "R7 last two disagree");
    send(32'h00520052, 0, 8'h52, 4'b1010, 0, 3'b000, 1, "R7 recovery");
    send(32'h99202020, 1, 8'h20, 4'b1000, 0, 3'b010, 1, "R8 clear and rejudge");
    send(32'h01020201, 1, 8'h01, 4'b0110, 0, 3'b111, 1, "R3 tie to lower index");
    send(32'h09090807, 1, 8'h09, 4'b0011, 0, 3'b101, 1, "R3 R5 upper pair wins");
    send(32'h04030201, 1, 8'h09, 4'b0000, 1, 3'b111, 1, "R7 R8 no group");
    send(32'h06060606, 0, 8'h06, 4'b0000, 0, 3'b000, 1, "R3 R9 all agree again");

    // every pair of failed modules, sequential and simultaneous
    pidx = 0;
    for (int a = 0; a < 4; a++) begin
      for (int b = a + 1; b < 4; b++) begin
        g  = 8'h40 + 8'(pidx * 4);
        g2 = g + 8'h01;
        send(mk(g, -1, 8'h00, -1, 8'h00), 1, g, 4'b0000, 0, 3'b000, 1, "R8 sweep clear");
        send(mk(g, a, ~g, -1, 8'h00), 0, g, 4'(1 << a), 0, 3'b000, 0, "R4 R5 first failure");
        send(mk(g, a, ~g, b, 8'h00), 0, g, 4'(1 << a) | 4'(1 << b), 0, 3'b000, 0,
             "R5 second failure grounded");
        send(mk(g2, a, ~g2, b, 8'h00), 0, g2, 4'(1 << a) | 4'(1 << b), 0, 3'b000, 1,
             "R5 R9 survivors carry new value");
        send(mk(g, a, ~g, b, 8'h00), 1, g, 4'(1 << a) | 4'(1 << b), 0, 3'b000, 0,
             "R5 simultaneous double failure");
        send(mk(g2, a, 8'h00, b, 8'hFF), 0, g2, 4'(1 << a) | 4'(1 << b), 0, 3'b000, 1,
             "R5 ignored modules after double failure");
        pidx++;
      end
    end

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule